// File: doc/BRIEF.md
# Fourth-Order Comb-Integrator Decimator, Ratio 32

This block is the first rate-reduction stage of an oversampled audio ADC. It takes the few-level code produced by an analog noise-shaping modulator, running at 128 times the audio rate, and delivers one sample for every 32 accepted codes. The result is a stream at 4 times the audio rate, ready for a droop-compensation stage and further halving stages downstream.

The filter is a fourth-power moving-sum response. It is realised as four cascaded accumulators clocked by the input strobe, then four first-difference sections clocked once per output. Every register uses wraparound two's-complement arithmetic. The integrators overflow freely during long runs. The differences cancel the overflow exactly, so the overall response is a 125-tap FIR with no recursion visible at the output.

An upstream source raises `in_stb` for one clock whenever a new code is present. It may leave gaps of any length between strobes. A downstream consumer takes `out_data` in the cycle where `out_valid` is high.

Top module: `cic_decim32`

## Requirements
- R1: Number the outputs k = 1, 2, ... from reset, and number the strobed input codes x[0], x[1], ... from reset. Output k equals the sum of h[j]·x[32k−1−j] over j = 0..124, where h is the fourfold self-convolution of a length-32 run of ones and codes before x[0] count as zero.
- R2: `out_valid` is high for exactly one clock per output, and `out_data` changes only in cycles where `out_valid` is high. The pulse appears in the cycle that starts two rising edges after the 32nd strobe is presented, where the edge that samples the strobe is the first of the two.
- R3: Clocks without `in_stb` change no filter state, so the output sequence depends only on the strobed codes and not on the gaps between them.
- R4: Exactly one output is produced for every 32 strobes counted from reset.
- R5: All internal registers are 25 bits wide and wrap modulo 2^25 without saturating. With a constant input c, every output from k = 4 onward equals c·2^20, even after the integrators have overflowed many times.
- R6: `in_code` is a 5-bit two's-complement code from −8 to +8 (up to 17 levels). A two-level input of alternating +8 and −8 is filtered to 0 once the window is full.
- R7: A synchronous active-high `rst` clears every register, including the strobe phase. While `rst` is held, `out_valid` and `out_data` read 0. Outputs 1 to 3 after reset are partial sums that cover only the codes received since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_stb | input | 1 | Qualifies `in_code` for one clock |
| in_code | input | 5 | Signed modulator code, −8..+8 |
| out_valid | output | 1 | One-clock pulse per decimated sample |
| out_data | output | 25 | Signed filtered sample |

## Verification
Two operations can fall in the same cycle. One is the update of the difference sections and the output register, triggered by the 32nd strobe. The other is the next integrator update, triggered by a strobe arriving on the very next clock. Back-to-back strobes in the constant and alternating patterns force this overlap at every output. Randomly gapped patterns separate the two operations for comparison. Each output is judged against a direct 125-tap convolution of the recorded input history, together with the exact cycle of its valid pulse.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int CIC_IN_W  = 5;
  localparam int CIC_RATE  = 32;
  localparam int CIC_ORDER = 4;

  // growth of a moving-sum cascade: order * log2(rate) bits above the input
  function automatic int cic_acc_w(input int in_w, input int rate, input int order);
    return in_w + order * $clog2(rate);
  endfunction
endpackage

// File: rtl/cic_phase_ctrl.sv
module cic_phase_ctrl #(
  parameter int RATE = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic in_stb,
  output logic dec_go
);
  localparam int PW = (RATE > 1) ? $clog2(RATE) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATE - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      dec_go <= 1'b0;
    end else begin
      dec_go <= in_stb && (phase == LAST);
      if (in_stb) phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  // R4: the last strobe of a block launches exactly one decimation step
  a_r4_go_after_last: assert property (@(posedge clk) disable iff (rst)
    (in_stb && phase == LAST) |=> dec_go);

  // R3: the phase only advances on a strobe
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !in_stb |=> $stable(phase));
endmodule

// File: rtl/cic_integ_stage.sv
module cic_integ_stage #(
  parameter int W = 25
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] d_in,
  output logic signed [W-1:0] acc,
  output logic signed [W-1:0] acc_nxt
);
  // modulo 2^W: the carry out is discarded on purpose
  assign acc_nxt = acc + d_in;

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= acc_nxt;
  end

  // R3: no strobe, no change
  a_r3_integ_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));
endmodule

// File: rtl/cic_comb_stage.sv
module cic_comb_stage #(
  parameter int W = 25
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] d_in,
  output logic signed [W-1:0] diff
);
  logic signed [W-1:0] prev;

  // first difference with a delay of one decimated sample, modulo 2^W
  assign diff = d_in - prev;

  always_ff @(posedge clk) begin
    if (rst)     prev <= '0;
    else if (en) prev <= d_in;
  end

  // R2: delay element moves only on a decimation step
  a_r2_comb_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(prev));
endmodule

// File: rtl/cic_decim32.sv
module cic_decim32
  import cic_pkg::*;
#(
  parameter int IN_W  = CIC_IN_W,
  parameter int RATE  = CIC_RATE,
  parameter int ORDER = CIC_ORDER,
  parameter int ACC_W = cic_acc_w(CIC_IN_W, CIC_RATE, CIC_ORDER)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_stb,
  input  logic signed [IN_W-1:0]  in_code,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_data
);
  logic                    dec_go;
  logic signed [ACC_W-1:0] i_in  [0:ORDER-1];
  logic signed [ACC_W-1:0] i_acc [0:ORDER-1];
  logic signed [ACC_W-1:0] c_in  [0:ORDER];
  logic signed [ACC_W-1:0] integ_tail_unused;

  assign i_in[0] = {{(ACC_W-IN_W){in_code[IN_W-1]}}, in_code};

  cic_phase_ctrl #(.RATE(RATE)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .in_stb (in_stb),
    .dec_go (dec_go)
  );

  // integrators: one unregistered chain per strobe, all at the input rate
  for (genvar s = 0; s < ORDER; s++) begin : g_integ
    if (s < ORDER - 1) begin : g_mid
      cic_integ_stage #(.W(ACC_W)) u_int (
        .clk     (clk),
        .rst     (rst),
        .en      (in_stb),
        .d_in    (i_in[s]),
        .acc     (i_acc[s]),
        .acc_nxt (i_in[s+1])
      );
    end else begin : g_tail
      cic_integ_stage #(.W(ACC_W)) u_int (
        .clk     (clk),
        .rst     (rst),
        .en      (in_stb),
        .d_in    (i_in[s]),
        .acc     (i_acc[s]),
        .acc_nxt (integ_tail_unused)
      );
    end
  end

  // combs: sample the last integrator one cycle after the block's final strobe
  assign c_in[0] = i_acc[ORDER-1];

  for (genvar s = 0; s < ORDER; s++) begin : g_comb
    cic_comb_stage #(.W(ACC_W)) u_comb (
      .clk  (clk),
      .rst  (rst),
      .en   (dec_go),
      .d_in (c_in[s]),
      .diff (c_in[s+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= dec_go;
      if (dec_go) out_data <= c_in[ORDER];
    end
  end

  // R2: single-cycle valid pulse
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R2: data moves only together with a valid pulse
  a_r2_data_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  // R7: reset leaves the output port cleared
  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));
endmodule

// File: tb/test_cic_decim32.sv
module test_cic_decim32;
  logic               clk = 1'b0;
  logic               rst;
  logic               in_stb;
  logic signed [4:0]  in_code;
  logic               out_valid;
  logic signed [24:0] out_data;

  always #10 clk = ~clk;

  cic_decim32 i_cic_decim32 (
    .clk       (clk),
    .rst       (rst),
    .in_stb    (in_stb),
    .in_code   (in_code),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  int checks = 0;
  int errors = 0;
  int n = 0;
  int kout = 0;
  int cyc = 0;
  int exp_cyc [0:255];
  logic signed [4:0] hist [0:4095];
  longint h [0:124];
  bit steady_on = 1'b0;
  int steady_from = 0;
  logic signed [24:0] steady = '0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic signed [24:0] model(input int k);
    longint s = 0;
    for (int j = 0; j < 125; j++) begin
      int m = 32 * k - 1 - j;
      if (m >= 0) s += h[j] * longint'(hist[m]);
    end
    return s[24:0];
  endfunction

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst) kout = 0;
    else if (out_valid) begin
      logic signed [24:0] e;
      kout = kout + 1;
      e = model(kout);
      chk(out_data == e, "R1 sinc4 output", out_data, e);
      chk(cyc == exp_cyc[kout], "R2 valid timing", cyc, exp_cyc[kout]);
      if (steady_on && kout >= steady_from)
        chk(out_data == steady, "R5 settled value", out_data, steady);
    end
  end

  task automatic send(input logic signed [4:0] code, input bit stb);
    @(negedge clk);
    in_code = code;
    in_stb  = stb;
    if (stb) begin
      hist[n] = code;
      n++;
      if (n % 32 == 0) exp_cyc[n / 32] = cyc + 2;
    end
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) send(5'sd0, 1'b0);
  endtask

  task automatic count_check(input string tag);
    idle(4);
    chk(kout == n / 32, tag, kout, n / 32);
  endtask

  task automatic do_reset();
    idle(3);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_data == '0, "R7 reset state", out_data, 0);
    rst = 1'b0;
    n = 0;
  endtask

  task automatic start_steady(input logic signed [24:0] v);
    steady      = v;
    steady_from = n / 32 + 4;
    steady_on   = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint a [0:124];
    longint b [0:124];
    for (int j = 0; j < 125; j++) a[j] = (j < 32) ? 1 : 0;
    for (int r = 0; r < 3; r++) begin
      for (int j = 0; j < 125; j++) begin
        b[j] = 0;
        for (int t = 0; t < 32; t++) if (j - t >= 0) b[j] += a[j - t];
      end
      for (int j = 0; j < 125; j++) a[j] = b[j];
    end
    for (int j = 0; j < 125; j++) h[j] = a[j];
    void'($urandom(32'd20240611));

    rst = 1'b1; in_stb = 1'b0; in_code = '0;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && out_data == '0, "R7 initial reset state", out_data, 0);
    rst = 1'b0;

    // R5: full-scale positive, back-to-back strobes (integrators wrap)
    start_steady(25'sd8388608);
    for (int i = 0; i < 320; i++) send(5'sd8, 1'b1);
    count_check("R4 output count const+8");

    // R3/R5: full-scale negative with random gaps
    start_steady(-25'sd8388608);
    for (int i = 0; i < 320; ) begin
      if ($urandom % 3 == 0) send(5'sd0, 1'b0);
      else begin send(-5'sd8, 1'b1); i++; end
    end
    count_check("R4 output count gapped");
    steady_on = 1'b0;

    // R6: two-level alternating input after a fresh reset
    do_reset();
    start_steady(25'sd0);
    for (int i = 0; i < 256; i++) send((i % 2 == 0) ? 5'sd8 : -5'sd8, 1'b1);
    count_check("R6 output count two-level");
    steady_on = 1'b0;

    // R7: reset in mid-block, phase must restart
    for (int i = 0; i < 20; i++) send(5'sd7, 1'b1);
    do_reset();

    // R1/R3: random 17-level codes with random gaps
    for (int i = 0; i < 1280; ) begin
      if ($urandom % 4 == 0) send(5'sd0, 1'b0);
      else begin
        send(5'(int'($urandom_range(16)) - 8), 1'b1);
        i++;
      end
    end
    count_check("R4 output count random");

    // R5: long small constant, many integrator wraps
    start_steady(25'sd1048576);
    for (int i = 0; i < 2240; i++) send(5'sd1, 1'b1);
    count_check("R4 output count long run");
    steady_on = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule